// File: doc/BRIEF.md
# Control Transfer Stage Sequencer

This block steps endpoint 0 through the setup, data and status stages of a USB control transfer. It watches five endpoint event flags: setup received, OUT data received, IN bank free, NAK answered to an IN token, and NAK answered to an OUT token. It also sees the direction bit and byte count of the received packet. It drives the per-event interrupt enables and one-cycle clear strobes for those flags, and it asks a request handler what to do with each setup, IN and OUT packet. The handler answers accept, delay or error.

The sequencer produces the outgoing packet length and a flag that asks the serial engine to append a zero-length packet. It also raises a stall request and a one-cycle pulse at the end of each status stage. That pulse lets a newly assigned bus address take effect only after the status handshake. The end of a data stage is detected when the host's token in the opposite direction gets a NAK.

Top module: `ctrl_xfer_seq`

## Requirements
- R1: After reset, `stage` is 0 (wait for setup), `irq_en` is 5'b00100 (setup only), and `hreq` is low. Bit positions for `irq_en`, `ev` and `ev_ack` are: 0 IN bank free, 1 OUT received, 2 setup, 3 NAK-on-OUT, 4 NAK-on-IN.
- R2: In stage 0, a setup event with `rx_bytes` other than 8 raises `stall_set` and `ev_ack[2]` in the same cycle, with no handler request. A setup answered with delay or error (`rsp_code` 1 or 2) also stalls and acknowledges. In every case the block stays in stage 0.
- R3: A valid setup raises `hreq` with `hreq_kind` 1 the cycle after it is seen. When the handler accepts (`rsp_code` 0), the setup flag is acknowledged. For direction IN, NAK-on-OUT is also acknowledged, and the next cycle has `irq_en`=5'b01001 and stage 1. For direction OUT, NAK-on-IN is also acknowledged, and the next cycle has `irq_en`=5'b10010 and stage 3.
- R4: In stage 1, NAK-on-OUT takes priority over IN bank free. It is acknowledged, and the next cycle is stage 2 with `irq_en`=5'b00010. If OUT received is set in the same cycle, that flag is acknowledged too, `status_done` pulses, and the block returns to stage 0.
- R5: In stage 1, IN bank free raises a request with `hreq_kind` 2. On accept, `pkt_load` pulses with `pkt_len`=`rsp_len` and `ev_ack[0]` is set. `pkt_zlp` is high only when `rsp_last` is set and `rsp_len` is 64. After a last packet, `irq_en` becomes 5'b01000.
- R6: A delayed IN request moves the block to stage 6 and clears the IN-bank-free enable. An IN error raises `stall_set` and returns the block to stage 0 with `irq_en`=5'b00100.
- R7: In stage 3, NAK-on-IN is acknowledged and the next cycle is stage 4 with `irq_en`=5'b00001. In stage 4, IN bank free loads a 0-byte packet with no zero-length flag, acknowledges the flag, and moves to stage 5. In stage 5, IN bank free pulses `status_done` and returns to stage 0 with `irq_en`=5'b00100.
- R8: In stage 3, OUT received raises a request with `hreq_kind` 3. Accept acknowledges the flag. Delay leaves it unacknowledged and clears `irq_en[1]`, after which the pending flag raises no further request.
- R9: In stage 2, OUT received is acknowledged, `status_done` pulses, and the next cycle is stage 0 with `irq_en`=5'b00100.
- R10: A setup event seen in any stage other than 0, while no request is outstanding, aborts the transfer. The next cycle is stage 0 with `irq_en`=5'b00100, and the pending setup is then handled normally.
- R11: `rsp_valid` while `hreq` is low has no effect: no strobe, no load, and no change of stage or enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev | input | 5 | Endpoint event flags (levels) |
| setup_dir_in | input | 1 | Direction bit of the setup packet, 1 = IN |
| rx_bytes | input | BCW | Byte count of the received packet |
| rsp_valid | input | 1 | Handler response strobe |
| rsp_code | input | 2 | 0 accept, 1 delay, 2/3 error |
| rsp_len | input | BCW | IN packet length from handler |
| rsp_last | input | 1 | IN packet is the last of the data stage |
| hreq | output | 1 | Handler request outstanding |
| hreq_kind | output | 2 | 1 setup, 2 IN packet, 3 OUT packet |
| irq_en | output | 5 | Interrupt enables per event |
| ev_ack | output | 5 | One-cycle clear strobes per event |
| stall_set | output | 1 | Request a stall handshake |
| pkt_load | output | 1 | Load outgoing packet length |
| pkt_len | output | BCW | Outgoing packet length |
| pkt_zlp | output | 1 | Append a zero-length packet |
| status_done | output | 1 | Status stage completed |
| stage | output | 3 | 0 setup wait, 1 IN data, 2 IN status, 3 OUT data, 4 OUT status send, 5 OUT status wait, 6 IN delayed |

## Verification
The hardest conditions to reach are those where two event flags are set in the same cycle. One is NAK-on-OUT together with OUT received during the IN data stage, which must end the transfer in one step. The other is a setup arriving while the block is parked in the delayed IN stage. The bench models the endpoint flags as sticky bits that clear on the block's strobes, and it can set several bits in one write. This lets it create such coincidences exactly. It also drives delay answers on purpose, leaving a flag set but masked, so it can confirm that the flag is left alone.

// File: rtl/ctrl_xfer_seq_pkg.sv
package ctrl_xfer_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_IN_DATA  = 3'd1,
        ST_IN_STS   = 3'd2,
        ST_OUT_DATA = 3'd3,
        ST_OUT_ZLP  = 3'd4,
        ST_OUT_FIN  = 3'd5,
        ST_IN_HOLD  = 3'd6
    } stage_e;

    typedef enum logic [1:0] {
        HK_NONE  = 2'd0,
        HK_SETUP = 2'd1,
        HK_IN    = 2'd2,
        HK_OUT   = 2'd3
    } hkind_e;

    typedef enum logic [1:0] {
        RC_ACCEPT = 2'd0,
        RC_DELAY  = 2'd1,
        RC_ERROR  = 2'd2,
        RC_ERROR2 = 2'd3
    } rcode_e;

    typedef struct packed {
        logic nak_in;
        logic nak_out;
        logic setup;
        logic out_rx;
        logic in_free;
    } evset_t;

    localparam evset_t EV_NONE    = 5'b00000;
    localparam evset_t EN_SETUP   = 5'b00100;
    localparam evset_t EN_IN_DATA = 5'b01001;
    localparam evset_t EN_OUT_DAT = 5'b10010;
    localparam evset_t EN_IN_STS  = 5'b00010;
    localparam evset_t EN_OUT_STS = 5'b00001;

    function automatic logic need_zlp(input logic last, input logic full);
        return last && full;
    endfunction

endpackage

// File: rtl/cxs_hreq.sv
module cxs_hreq
    import ctrl_xfer_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  hkind_e issue,
    input  logic   rsp_valid,
    output hkind_e pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= HK_NONE;
        else if (pend != HK_NONE && rsp_valid)
            pend <= HK_NONE;
        else if (pend == HK_NONE && issue != HK_NONE)
            pend <= issue;
    end
endmodule

// File: rtl/cxs_pkt_fmt.sv
module cxs_pkt_fmt
    import ctrl_xfer_seq_pkg::*;
#(
    parameter int BCW  = 15,
    parameter int MAXP = 64
) (
    input  logic           load,
    input  logic           zero_pkt,
    input  logic [BCW-1:0] rsp_len,
    input  logic           rsp_last,
    output logic           pkt_load,
    output logic [BCW-1:0] pkt_len,
    output logic           pkt_zlp
);
    logic full;
    assign full     = (rsp_len == BCW'(MAXP));
    assign pkt_load = load;
    assign pkt_len  = (load && !zero_pkt) ? rsp_len : '0;
    assign pkt_zlp  = load && !zero_pkt && need_zlp(rsp_last, full);
endmodule

// File: rtl/cxs_stage_fsm.sv
module cxs_stage_fsm
    import ctrl_xfer_seq_pkg::*;
#(
    parameter int BCW       = 15,
    parameter int SETUP_LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  evset_t         ev,
    input  logic           dir_in,
    input  logic [BCW-1:0] rx_bytes,
    input  hkind_e         pend,
    input  logic           rsp_valid,
    input  rcode_e         rsp_code,
    input  logic           rsp_last,
    output stage_e         stage,
    output evset_t         en,
    output evset_t         ack,
    output logic           stall_set,
    output hkind_e         issue,
    output logic           load,
    output logic           zero_pkt,
    output logic           status_done
);
    stage_e st_n;
    evset_t en_n;
    logic   dir_r, dir_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= ST_IDLE;
            en    <= EN_SETUP;
            dir_r <= 1'b0;
        end else begin
            stage <= st_n;
            en    <= en_n;
            dir_r <= dir_n;
        end
    end

    always_comb begin
        st_n        = stage;
        en_n        = en;
        dir_n       = dir_r;
        ack         = EV_NONE;
        stall_set   = 1'b0;
        issue       = HK_NONE;
        load        = 1'b0;
        zero_pkt    = 1'b0;
        status_done = 1'b0;
        if (pend != HK_NONE) begin
            if (rsp_valid) begin
                case (pend)
                    HK_SETUP: begin
                        ack.setup = 1'b1;
                        if (rsp_code == RC_ACCEPT) begin
                            if (dir_r) begin
                                ack.nak_out = 1'b1;
                                en_n        = EN_IN_DATA;
                                st_n        = ST_IN_DATA;
                            end else begin
                                ack.nak_in = 1'b1;
                                en_n       = EN_OUT_DAT;
                                st_n       = ST_OUT_DATA;
                            end
                        end else begin
                            stall_set = 1'b1;
                        end
                    end
                    HK_IN: begin
                        if (rsp_code == RC_ACCEPT) begin
                            load        = 1'b1;
                            ack.in_free = 1'b1;
                            if (rsp_last) en_n.in_free = 1'b0;
                        end else if (rsp_code == RC_DELAY) begin
                            en_n.in_free = 1'b0;
                            st_n         = ST_IN_HOLD;
                        end else begin
                            stall_set = 1'b1;
                            en_n      = EN_SETUP;
                            st_n      = ST_IDLE;
                        end
                    end
                    HK_OUT: begin
                        if (rsp_code == RC_ACCEPT) begin
                            ack.out_rx = 1'b1;
                        end else if (rsp_code == RC_DELAY) begin
                            en_n.out_rx = 1'b0;
                        end else begin
                            stall_set = 1'b1;
                            en_n      = EN_SETUP;
                            st_n      = ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (ev.setup && stage != ST_IDLE) begin
            en_n = EN_SETUP;
            st_n = ST_IDLE;
        end else begin
            case (stage)
                ST_IDLE: begin
                    if (ev.setup) begin
                        if (rx_bytes != BCW'(SETUP_LEN)) begin
                            stall_set = 1'b1;
                            ack.setup = 1'b1;
                        end else begin
                            issue = HK_SETUP;
                            dir_n = dir_in;
                        end
                    end
                end
                ST_IN_DATA: begin
                    if (ev.nak_out) begin
                        ack.nak_out = 1'b1;
                        if (ev.out_rx) begin
                            ack.out_rx  = 1'b1;
                            status_done = 1'b1;
                            en_n        = EN_SETUP;
                            st_n        = ST_IDLE;
                        end else begin
                            en_n = EN_IN_STS;
                            st_n = ST_IN_STS;
                        end
                    end else if (ev.in_free && en.in_free) begin
                        issue = HK_IN;
                    end
                end
                ST_IN_STS: begin
                    if (ev.out_rx) begin
                        ack.out_rx  = 1'b1;
                        status_done = 1'b1;
                        en_n        = EN_SETUP;
                        st_n        = ST_IDLE;
                    end
                end
                ST_OUT_DATA: begin
                    if (ev.out_rx && en.out_rx) begin
                        issue = HK_OUT;
                    end else if (ev.nak_in) begin
                        ack.nak_in = 1'b1;
                        en_n       = EN_OUT_STS;
                        st_n       = ST_OUT_ZLP;
                    end
                end
                ST_OUT_ZLP: begin
                    if (ev.in_free) begin
                        load        = 1'b1;
                        zero_pkt    = 1'b1;
                        ack.in_free = 1'b1;
                        st_n        = ST_OUT_FIN;
                    end
                end
                ST_OUT_FIN: begin
                    if (ev.in_free) begin
                        status_done = 1'b1;
                        en_n        = EN_SETUP;
                        st_n        = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctrl_xfer_seq.sv
module ctrl_xfer_seq
    import ctrl_xfer_seq_pkg::*;
#(
    parameter int BCW       = 15,
    parameter int MAXP      = 64,
    parameter int SETUP_LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [4:0]     ev,
    input  logic           setup_dir_in,
    input  logic [BCW-1:0] rx_bytes,
    input  logic           rsp_valid,
    input  logic [1:0]     rsp_code,
    input  logic [BCW-1:0] rsp_len,
    input  logic           rsp_last,
    output logic           hreq,
    output logic [1:0]     hreq_kind,
    output logic [4:0]     irq_en,
    output logic [4:0]     ev_ack,
    output logic           stall_set,
    output logic           pkt_load,
    output logic [BCW-1:0] pkt_len,
    output logic           pkt_zlp,
    output logic           status_done,
    output logic [2:0]     stage
);
    hkind_e pend, issue;
    stage_e st;
    evset_t en_s, ack_s;
    logic   load, zero_pkt;

    cxs_hreq u_hreq (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .rsp_valid (rsp_valid),
        .pend      (pend)
    );

    cxs_stage_fsm #(.BCW(BCW), .SETUP_LEN(SETUP_LEN)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (evset_t'(ev)),
        .dir_in      (setup_dir_in),
        .rx_bytes    (rx_bytes),
        .pend        (pend),
        .rsp_valid   (rsp_valid),
        .rsp_code    (rcode_e'(rsp_code)),
        .rsp_last    (rsp_last),
        .stage       (st),
        .en          (en_s),
        .ack         (ack_s),
        .stall_set   (stall_set),
        .issue       (issue),
        .load        (load),
        .zero_pkt    (zero_pkt),
        .status_done (status_done)
    );

    cxs_pkt_fmt #(.BCW(BCW), .MAXP(MAXP)) u_fmt (
        .load     (load),
        .zero_pkt (zero_pkt),
        .rsp_len  (rsp_len),
        .rsp_last (rsp_last),
        .pkt_load (pkt_load),
        .pkt_len  (pkt_len),
        .pkt_zlp  (pkt_zlp)
    );

    assign hreq      = (pend != HK_NONE);
    assign hreq_kind = pend;
    assign irq_en    = en_s;
    assign ev_ack    = ack_s;
    assign stage     = st;
endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
    parameter int BCW  = 15,
    parameter int MAXP = 64
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     stage,
    input logic [4:0]     irq_en,
    input logic           stall_set,
    input logic           pkt_load,
    input logic [BCW-1:0] pkt_len,
    input logic           pkt_zlp,
    input logic           status_done,
    input logic           hreq,
    input logic           rsp_valid,
    input logic [4:0]     ev_ack
);
    AST_ZLP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        pkt_zlp |-> (pkt_load && pkt_len == BCW'(MAXP))); // R5

    AST_STALL_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        stall_set |=> (stage == 3'd0)); // R2

    AST_IN_DATA_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd1 && $past(stage) == 3'd0) |-> (irq_en == 5'b01001)); // R3

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        status_done |=> (stage == 3'd0 && irq_en == 5'b00100)); // R9

    AST_OUT_ZLP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd4 && pkt_load) |-> (pkt_len == '0 && !pkt_zlp)); // R7

    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !hreq && stage == 3'd0 && $stable(stage)) |-> (!pkt_load)); // R11
endmodule

bind ctrl_xfer_seq cxs_checker #(.BCW(BCW), .MAXP(MAXP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stage       (stage),
    .irq_en      (irq_en),
    .stall_set   (stall_set),
    .pkt_load    (pkt_load),
    .pkt_len     (pkt_len),
    .pkt_zlp     (pkt_zlp),
    .status_done (status_done),
    .hreq        (hreq),
    .rsp_valid   (rsp_valid),
    .ev_ack      (ev_ack)
);

// File: tb/ctrl_xfer_seq_test.sv
module ctrl_xfer_seq_test;
    localparam int BCW = 15;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [4:0]     flags;
    logic [4:0]     flag_set = '0;
    logic [4:0]     flag_clr = '0;
    logic           setup_dir_in = 1'b0;
    logic [BCW-1:0] rx_bytes = BCW'(8);
    logic           rsp_valid = 1'b0;
    logic [1:0]     rsp_code = 2'd0;
    logic [BCW-1:0] rsp_len = '0;
    logic           rsp_last = 1'b0;
    logic           hreq;
    logic [1:0]     hreq_kind;
    logic [4:0]     irq_en, ev_ack;
    logic           stall_set, pkt_load, pkt_zlp, status_done;
    logic [BCW-1:0] pkt_len;
    logic [2:0]     stage;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~ev_ack & ~flag_clr) | flag_set;
    end

    ctrl_xfer_seq uut (
        .clk(clk), .rst(rst), .ev(flags), .setup_dir_in(setup_dir_in),
        .rx_bytes(rx_bytes), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_len(rsp_len), .rsp_last(rsp_last), .hreq(hreq),
        .hreq_kind(hreq_kind), .irq_en(irq_en), .ev_ack(ev_ack),
        .stall_set(stall_set), .pkt_load(pkt_load), .pkt_len(pkt_len),
        .pkt_zlp(pkt_zlp), .status_done(status_done), .stage(stage)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic raise(input logic [4:0] bits);
        flag_set = bits;
        tick();
        flag_set = '0;
    endtask

    task automatic clear_all;
        flag_clr = 5'b11111;
        tick();
        flag_clr = '0;
    endtask

    task automatic respond(input logic [1:0] code, input int len, input logic last);
        rsp_valid = 1'b1;
        rsp_code  = code;
        rsp_len   = BCW'(len);
        rsp_last  = last;
        #1;
    endtask

    task automatic release_rsp;
        rsp_valid = 1'b0;
    endtask

    task automatic accept_setup(input logic dir, input string tag);
        setup_dir_in = dir;
        rx_bytes = BCW'(8);
        raise(5'b00100);
        tick();
        check({tag, " R3 hreq"}, int'(hreq), 1);
        check({tag, " R11 kind setup"}, int'(hreq_kind), 1);
        respond(2'd0, 0, 1'b0);
        check({tag, " R3 ack"}, int'(ev_ack), dir ? 5'b01100 : 5'b10100);
        tick();
        release_rsp();
        check({tag, " R3 stage"}, int'(stage), dir ? 1 : 3);
        check({tag, " R3 irq_en"}, int'(irq_en), dir ? 5'b01001 : 5'b10010);
    endtask

    task automatic in_packet(input int len, input logic last, input int zlp, input string tag);
        raise(5'b00001);
        tick();
        check({tag, " R5 kind IN"}, int'(hreq_kind), 2);
        respond(2'd0, len, last);
        check({tag, " R5 load"}, int'(pkt_load), 1);
        check({tag, " R5 len"}, int'(pkt_len), len);
        check({tag, " R5 zlp"}, int'(pkt_zlp), zlp);
        check({tag, " R5 ack"}, int'(ev_ack), 5'b00001);
        tick();
        release_rsp();
    endtask

    task automatic t_reset;
        check("R1 stage", int'(stage), 0);
        check("R1 irq_en", int'(irq_en), 5'b00100);
        check("R1 hreq", int'(hreq), 0);
    endtask

    task automatic t_bad_len;
        rx_bytes = BCW'(7);
        raise(5'b00100);
        check("R2 short stall", int'(stall_set), 1);
        check("R2 short ack", int'(ev_ack), 5'b00100);
        tick();
        check("R2 short stage", int'(stage), 0);
        check("R2 short no hreq", int'(hreq), 0);
        rx_bytes = BCW'(8);
    endtask

    task automatic t_setup_err;
        raise(5'b00100);
        tick();
        respond(2'd2, 0, 1'b0);
        check("R2 err stall", int'(stall_set), 1);
        tick();
        release_rsp();
        check("R2 err stage", int'(stage), 0);
        raise(5'b00100);
        tick();
        respond(2'd1, 0, 1'b0);
        check("R2 delay stall", int'(stall_set), 1);
        tick();
        release_rsp();
        check("R2 delay stage", int'(stage), 0);
    endtask

    task automatic t_ctrl_read;
        accept_setup(1'b1, "read");
        in_packet(64, 1'b0, 0, "read mid");
        check("R5 mid irq", int'(irq_en), 5'b01001);
        in_packet(64, 1'b1, 1, "read full last");
        check("R5 last irq", int'(irq_en), 5'b01000);
        raise(5'b01000);
        check("R4 nak_out ack", int'(ev_ack), 5'b01000);
        tick();
        check("R4 stage", int'(stage), 2);
        check("R4 irq", int'(irq_en), 5'b00010);
        raise(5'b00010);
        check("R9 ack", int'(ev_ack), 5'b00010);
        check("R9 done", int'(status_done), 1);
        tick();
        check("R9 stage", int'(stage), 0);
        check("R9 irq", int'(irq_en), 5'b00100);
    endtask

    task automatic t_read_short;
        accept_setup(1'b1, "short");
        in_packet(20, 1'b1, 0, "short last");
        raise(5'b01011);
        check("R4 priority ack", int'(ev_ack), 5'b01010);
        check("R4 same pass done", int'(status_done), 1);
        check("R4 no IN issue", int'(pkt_load), 0);
        tick();
        check("R4 same pass stage", int'(stage), 0);
        clear_all();
    endtask

    task automatic t_in_delay_abort;
        accept_setup(1'b1, "delay");
        raise(5'b00001);
        tick();
        respond(2'd1, 8, 1'b0);
        check("R6 delay no load", int'(pkt_load), 0);
        tick();
        release_rsp();
        check("R6 delay stage", int'(stage), 6);
        check("R6 delay irq", int'(irq_en), 5'b01000);
        raise(5'b00100);
        tick();
        check("R10 abort stage", int'(stage), 0);
        check("R10 abort irq", int'(irq_en), 5'b00100);
        tick();
        check("R10 setup re-requested", int'(hreq_kind), 1);
        respond(2'd2, 0, 1'b0);
        tick();
        release_rsp();
        clear_all();
    endtask

    task automatic t_in_err;
        accept_setup(1'b1, "inerr");
        raise(5'b00001);
        tick();
        respond(2'd2, 8, 1'b0);
        check("R6 err stall", int'(stall_set), 1);
        tick();
        release_rsp();
        check("R6 err stage", int'(stage), 0);
        check("R6 err irq", int'(irq_en), 5'b00100);
        clear_all();
    endtask

    task automatic t_ctrl_write;
        accept_setup(1'b0, "write");
        rx_bytes = BCW'(16);
        raise(5'b00010);
        tick();
        check("R8 kind OUT", int'(hreq_kind), 3);
        respond(2'd0, 0, 1'b0);
        check("R8 accept ack", int'(ev_ack), 5'b00010);
        tick();
        release_rsp();
        raise(5'b00010);
        tick();
        respond(2'd1, 0, 1'b0);
        check("R8 delay no ack", int'(ev_ack), 0);
        tick();
        release_rsp();
        check("R8 delay irq", int'(irq_en), 5'b10000);
        tick();
        check("R8 masked no hreq", int'(hreq), 0);
        raise(5'b10000);
        check("R7 nak_in ack", int'(ev_ack), 5'b10000);
        tick();
        check("R7 stage send", int'(stage), 4);
        check("R7 irq", int'(irq_en), 5'b00001);
        raise(5'b00001);
        check("R7 zlp load", int'(pkt_load), 1);
        check("R7 zlp len", int'(pkt_len), 0);
        check("R7 zlp flag", int'(pkt_zlp), 0);
        tick();
        check("R7 stage wait", int'(stage), 5);
        raise(5'b00001);
        check("R7 done", int'(status_done), 1);
        tick();
        check("R7 stage idle", int'(stage), 0);
        check("R7 irq idle", int'(irq_en), 5'b00100);
        clear_all();
        rx_bytes = BCW'(8);
    endtask

    task automatic t_stray;
        respond(2'd0, 64, 1'b1);
        check("R11 no ack", int'(ev_ack), 0);
        check("R11 no load", int'(pkt_load), 0);
        tick();
        release_rsp();
        check("R11 stage", int'(stage), 0);
        check("R11 irq", int'(irq_en), 5'b00100);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_bad_len();
        t_setup_err();
        t_ctrl_read();
        t_read_short();
        t_in_delay_abort();
        t_in_err();
        t_ctrl_write();
        t_stray();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule